// File: doc/BRIEF.md
# Delay-Based Temperature Measurement Sequencer

This block sequences a temperature sensor that works by timing a discharge. Once per measurement period it charges a sense capacitor. It then switches on a discharge path through a transistor held in weak inversion and counts system clocks until a comparator reports that the capacitor voltage has fallen through the threshold. The current through that transistor depends strongly on temperature, so the elapsed count serves as the temperature code. The count is limited to 6 bits. While the discharge path is open, the block also drives the digital setting of the bias DAC for that transistor.

The state machine has four states:
- **IDLE** waits for the period tick (IDLE→PRECHARGE on tick).
- **PRECHARGE** holds the precharge enable for a fixed number of cycles (PRECHARGE→DISCHARGE when the cycle count is done).
- **DISCHARGE** opens the discharge path and counts (DISCHARGE→LATCH when the synchronized comparator input is high or the count reaches 63).
- **LATCH** transfers the count to the result register (LATCH→IDLE, always).

The comparator input is asynchronous and passes through two flip-flops before it is used. The analog devices sit outside this block. A prescaler divides the system clock so that one measurement starts per second; the bench uses a short period.

Top module: `tsense_seq`

## Requirements
- R1: The first precharge begins PERIOD cycles after reset is released, and a new measurement begins every PERIOD cycles after that.
- R2: `precharge_o` stays high for exactly PRE_CYC consecutive cycles in each measurement and is never high together with `discharge_en_o`.
- R3: `discharge_en_o` rises in the cycle directly after precharge ends and stays high until the measurement stops counting.
- R4: `bias_o` equals BIAS_CODE in every cycle where `discharge_en_o` is high, and is zero in all other cycles.
- R5: `discharged_i` goes through a two-flop synchronizer. If it is high at the clock edge that closes discharge cycle k (k = 0 for the first discharge cycle), the latched code is k+2, capped at 63.
- R6: If the comparator never fires, the code saturates at 63 after 64 discharge cycles, and the sequencer still latches and returns to IDLE.
- R7: `valid_o` is a one-cycle pulse in the second cycle after the last discharge cycle. `code_o` takes its new value in that same cycle and keeps it at all other times.
- R8: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| discharged_i | input | 1 | Comparator output, high once the capacitor is discharged (asynchronous) |
| precharge_o | output | 1 | Precharge switch enable for the sense capacitor |
| discharge_en_o | output | 1 | Discharge path enable |
| bias_o | output | DAC_W | Bias DAC setting, BIAS_CODE during discharge, zero otherwise |
| code_o | output | CODE_W | Latched raw temperature code, 0 to 63 |
| valid_o | output | 1 | One-cycle pulse when a new code is latched |

## Verification
Each result has a fixed latency:
- A period tick is seen as `precharge_o` one cycle after the last prescaler count.
- A comparator edge that is sampled at the end of discharge cycle k ends the discharge two cycles later.
- `code_o` and `valid_o` follow the last discharge cycle by two cycles, one cycle for LATCH and one for the result register.

The bench steps a behavioural reference model on each rising edge and applies the same latencies. It compares every output at the falling edge and also checks each latched code against the closed form min(D+1, 63), where D is the delay of the modelled capacitor. The delays cover the shortest possible discharge, mid-range values, the boundary where the count and the synchronized input meet at 63, and a comparator that never fires.

// File: rtl/tsense_pkg.sv
package tsense_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PRECHARGE = 2'd1,
        ST_DISCHARGE = 2'd2,
        ST_LATCH     = 2'd3
    } tsense_state_e;
endpackage

// File: rtl/tsense_prescaler.sv
module tsense_prescaler #(
    parameter int PERIOD = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tsense_sync2.sv
module tsense_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/tsense_satcnt.sv
module tsense_satcnt #(
    parameter int WIDTH = 6,
    parameter int MAX   = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             at_max_o
);
    localparam logic [WIDTH-1:0] TOP = WIDTH'(MAX);

    logic [WIDTH-1:0] cnt_q;

    assign at_max_o = (cnt_q == TOP);
    assign cnt_o    = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (en_i && !at_max_o)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/tsense_seq.sv
module tsense_seq
    import tsense_pkg::*;
#(
    parameter int PERIOD    = 50_000_000,
    parameter int PRE_CYC   = 4,
    parameter int CODE_W    = 6,
    parameter int DAC_W     = 4,
    parameter int BIAS_CODE = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              discharged_i,
    output logic              precharge_o,
    output logic              discharge_en_o,
    output logic [DAC_W-1:0]  bias_o,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int PRE_W    = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;

    tsense_state_e    state_q, state_d;
    logic             tick;
    logic             dis_sync;
    logic [PRE_W-1:0] pre_cnt;
    logic             pre_done;
    logic [CODE_W-1:0] dly_cnt;
    logic             dly_sat;
    logic [CODE_W-1:0] code_q;
    logic             valid_q;

    tsense_prescaler #(.PERIOD(PERIOD)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tsense_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (discharged_i),
        .sync_o  (dis_sync)
    );

    tsense_satcnt #(.WIDTH(PRE_W), .MAX(PRE_CYC - 1)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_q != ST_PRECHARGE),
        .en_i     (state_q == ST_PRECHARGE),
        .cnt_o    (pre_cnt),
        .at_max_o (pre_done)
    );

    tsense_satcnt #(.WIDTH(CODE_W), .MAX(CODE_MAX)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_q == ST_PRECHARGE),
        .en_i     ((state_q == ST_DISCHARGE) && !dis_sync),
        .cnt_o    (dly_cnt),
        .at_max_o (dly_sat)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (tick) state_d = ST_PRECHARGE;
            ST_PRECHARGE: if (pre_done) state_d = ST_DISCHARGE;
            ST_DISCHARGE: if (dis_sync || dly_sat) state_d = ST_LATCH;
            ST_LATCH:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Moore outputs toward the analog front end
    always_comb begin
        precharge_o    = 1'b0;
        discharge_en_o = 1'b0;
        bias_o         = '0;
        unique case (state_q)
            ST_PRECHARGE: precharge_o = 1'b1;
            ST_DISCHARGE: begin
                discharge_en_o = 1'b1;
                bias_o         = DAC_W'(BIAS_CODE);
            end
            default: ;
        endcase
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (state_q == ST_LATCH);
            if (state_q == ST_LATCH)
                code_q <= dly_cnt;
        end
    end

    assign code_o  = code_q;
    assign valid_o = valid_q;

    logic unused_pre;
    assign unused_pre = ^pre_cnt;
endmodule

// File: rtl/tsense_seq_chk.sv
module tsense_seq_chk #(
    parameter int CODE_W    = 6,
    parameter int DAC_W     = 4,
    parameter int BIAS_CODE = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              precharge_o,
    input logic              discharge_en_o,
    input logic [DAC_W-1:0]  bias_o,
    input logic [CODE_W-1:0] code_o,
    input logic              valid_o
);
    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(precharge_o && discharge_en_o));

    // R3
    discharge_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(discharge_en_o) |-> $past(precharge_o));

    // R3
    pre_hands_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(precharge_o) |-> discharge_en_o);

    // R4
    bias_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !discharge_en_o |-> (bias_o == '0));

    // R4
    bias_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        discharge_en_o |-> (bias_o == DAC_W'(BIAS_CODE)));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(code_o));

    // R7
    valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!$past(discharge_en_o) && $past(discharge_en_o, 2)));
endmodule

bind tsense_seq tsense_seq_chk #(
    .CODE_W    (CODE_W),
    .DAC_W     (DAC_W),
    .BIAS_CODE (BIAS_CODE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .precharge_o    (precharge_o),
    .discharge_en_o (discharge_en_o),
    .bias_o         (bias_o),
    .code_o         (code_o),
    .valid_o        (valid_o)
);

// File: tb/tsense_seq_tb.sv
module tsense_seq_tb;
    localparam int P    = 200;
    localparam int PRE  = 4;
    localparam int BIAS = 10;
    localparam int NM   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       raw = 1'b0;
    logic       pre, dis, vld;
    logic [3:0] bias;
    logic [5:0] code;

    int checks = 0;
    int fails  = 0;

    int dly_tab [NM] = '{5, 20, 1, 61, 62, 100};
    int idx = 0;
    bit run = 1'b0;

    // reference model state
    int mph = 0, mtimer = 0, mpre = 0, mcnt = 0, mcode = 0;
    int ms1 = 0, ms2 = 0, mvalid = 0, en_cyc = 0;

    always #10 clk = ~clk;

    tsense_seq #(.PERIOD(P), .PRE_CYC(PRE), .CODE_W(6), .DAC_W(4), .BIAS_CODE(BIAS)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .discharged_i   (raw),
        .precharge_o    (pre),
        .discharge_en_o (dis),
        .bias_o         (bias),
        .code_o         (code),
        .valid_o        (vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, stepped on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mph = 0; mtimer = 0; mpre = 0; mcnt = 0; mcode = 0;
            ms1 = 0; ms2 = 0; mvalid = 0;
        end else begin
            bit tk;
            tk = (mtimer == P - 1);
            mtimer = tk ? 0 : mtimer + 1;
            mvalid = (mph == 3) ? 1 : 0;
            if (mph == 3) mcode = mcnt;
            case (mph)
                0: if (tk) begin mph = 1; mpre = 0; end
                1: if (mpre == PRE - 1) begin mph = 2; mcnt = 0; end
                   else mpre = mpre + 1;
                2: if (ms2 != 0 || mcnt == 63) mph = 3;
                   else mcnt = mcnt + 1;
                default: mph = 0;
            endcase
            ms2 = ms1;
            ms1 = raw ? 1 : 0;
        end
    end

    // compare every cycle at the falling edge, then drive the capacitor model
    always @(negedge clk) begin
        if (run) begin
            int ed;
            ed = (mph == 2) ? 1 : 0;
            chk("R1/R2 precharge", int'(pre), (mph == 1) ? 1 : 0);
            chk("R3/R6 discharge", int'(dis), ed);
            chk("R4 bias", int'(bias), ed ? BIAS : 0);
            chk("R7 valid", int'(vld), mvalid);
            chk("R5/R7 code", int'(code), mcode);
            if (mvalid != 0 && idx < NM) begin
                int want;
                want = (dly_tab[idx] + 1 > 63) ? 63 : dly_tab[idx] + 1;
                if (want == 63) chk("R6 saturated code", int'(code), want);
                else            chk("R5 delay code", int'(code), want);
                idx++;
            end
            if (ed != 0) en_cyc++; else en_cyc = 0;
            raw = (ed != 0) && (idx < NM) && (en_cyc >= dly_tab[idx]);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 precharge", int'(pre), 0);
        chk("R8 discharge", int'(dis), 0);
        chk("R8 bias", int'(bias), 0);
        chk("R8 code", int'(code), 0);
        chk("R8 valid", int'(vld), 0);
        run = 1'b1;
        rst_n = 1'b1;
        fork
            begin
                wait (idx == NM);
                repeat (5) @(negedge clk);
            end
            begin
                repeat (P * (NM + 3)) @(negedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d measurements expected %0d", idx, NM);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule